// File: doc/BRIEF.md
# Standby Duty-Cycling Power Controller

This host-side controller lowers the average power drawn by a data converter. It keeps the converter in its low-power standby state whenever no conversion sequence is running. It watches the converter's busy output. When a sequence ends, the controller pulls the active-low standby line low and starts counting how long the converter stays asleep. When the next conversion request arrives, it raises the standby line again and waits for a wake-up interval. Only then does it issue a one-cycle start pulse to the converter.

The wake-up interval depends on the reference mode and, for the internal reference, on how long the converter slept. An external reference always uses one short wait. With the internal reference, a short sleep gives a short wait and a medium sleep gives a longer wait. A long sleep gives the longest wait, because the reference capacitor has to recharge. Every interval and threshold is a cycle-count parameter. The meaning of "short", "medium" and "long" therefore comes from the system clock period chosen at integration.

Requests that come in while a wake-up or a sequence is in progress are held in a single flag. That flag is served once, after the current sequence finishes. There is no data path, so all pins are plain control and status signals.

Top module: `stby_pwr_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `stby_n_o` is 1, `start_o` is 0 and `ready_o` is 1 (awake and idle).
- R2: When awake and idle, a request sampled at a clock edge makes `start_o` high in the very next cycle, with no wake-up wait, and `stby_n_o` stays 1.
- R3: After a started sequence, `stby_n_o` goes low in the cycle after `busy_i` is first sampled low following its high phase. `stby_n_o` never falls unless `busy_i` was low in the cycle before.
- R4: With `ref_ext_i` = 1 when a request is accepted in standby, `stby_n_o` is high for exactly WAKE_EXT cycles before the cycle in which `start_o` is high, whatever the standby duration.
- R5: With `ref_ext_i` = 0, let D be the number of cycles `stby_n_o` was low, counting the cycle in which the request is sampled. If D < SLEEP_MID, the wait is WAKE_SHORT cycles.
- R6: With `ref_ext_i` = 0 and SLEEP_MID <= D < SLEEP_LONG, the wait is WAKE_MID cycles.
- R7: With `ref_ext_i` = 0 and D >= SLEEP_LONG, the wait is WAKE_LONG cycles. The standby counter saturates, so any longer standby gives the same wait.
- R8: `start_o` is one cycle wide, is never high while `stby_n_o` is low, and is never high in the first awake cycle after standby.
- R9: `ready_o` is 1 in idle and in standby. It is 0 from the cycle after a request is accepted until standby is entered again (during the wake-up wait, the start pulse and the busy phase).
- R10: Any number of requests that arrive during a wake-up wait or a sequence collapse into one held request. After the sequence ends, that request causes exactly one standby cycle, one wake-up (with D = 1) and one further start pulse, and no more.
- R11: `ref_ext_i` matters only in the cycle in which the request is accepted in standby. Changing it during the wake-up wait does not change the wait length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_req | input | 1 | Conversion request; each cycle it is high counts as a request |
| busy_i | input | 1 | Busy output of the converter, high during a sequence |
| ref_ext_i | input | 1 | 1 = external reference, 0 = internal reference |
| stby_n_o | output | 1 | Active-low standby line to the converter |
| start_o | output | 1 | One-cycle start pulse to the converter |
| ready_o | output | 1 | High when no wake-up or sequence is in progress |

## Verification
The bench sweeps the standby length from one cycle to beyond the saturation limit, for both reference modes. It checks that the measured wait equals the tier computed from D. An off-by-one in the duration count or in a tier threshold would give the wrong wait exactly at the SLEEP_MID and SLEEP_LONG boundaries. The reference input is flipped right after each request, so a design that reads it late would pick the wrong tier. Several requests are sent during a wake-up and a busy phase: a counting queue would start extra sequences, and a design that drops held requests would never wake again.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_ARM,
    ST_RUN,
    ST_SLEEP,
    ST_WAKE
  } spc_state_e;

  typedef enum logic [1:0] {
    TIER_EXT,
    TIER_SHORT,
    TIER_MID,
    TIER_LONG
  } spc_tier_e;
endpackage

// File: rtl/spc_sleep_meter.sv
module spc_sleep_meter
  import spc_pkg::*;
#(
  parameter int unsigned SLEEP_MID  = 4,
  parameter int unsigned SLEEP_LONG = 8,
  parameter int unsigned SW         = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleeping,
  input  logic      ref_ext,
  output spc_tier_e tier
);
  logic [SW-1:0] cnt_q;
  logic [SW:0]   dur;

  // cnt_q holds completed standby cycles; saturates at SLEEP_LONG
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (!sleeping)                 cnt_q <= '0;
    else if (cnt_q != SW'(SLEEP_LONG))  cnt_q <= cnt_q + 1'b1;
  end

  // duration including the current standby cycle
  assign dur = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    if (ref_ext)                          tier = TIER_EXT;
    else if (dur < (SW+1)'(SLEEP_MID))    tier = TIER_SHORT;
    else if (dur < (SW+1)'(SLEEP_LONG))   tier = TIER_MID;
    else                                  tier = TIER_LONG;
  end
endmodule

// File: rtl/spc_wake_timer.sv
module spc_wake_timer
  import spc_pkg::*;
#(
  parameter int unsigned WAKE_EXT   = 2,
  parameter int unsigned WAKE_SHORT = 3,
  parameter int unsigned WAKE_MID   = 5,
  parameter int unsigned WAKE_LONG  = 7,
  parameter int unsigned WW         = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  spc_tier_e tier,
  output logic      done
);
  logic [WW-1:0] len;
  logic [WW-1:0] cnt_q;

  always_comb begin
    unique case (tier)
      TIER_EXT:   len = WW'(WAKE_EXT);
      TIER_SHORT: len = WW'(WAKE_SHORT);
      TIER_MID:   len = WW'(WAKE_MID);
      default:    len = WW'(WAKE_LONG);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= len;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // high in the last cycle of the wait
  assign done = (cnt_q == WW'(1));
endmodule

// File: rtl/spc_seq_fsm.sv
module spc_seq_fsm
  import spc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic conv_req,
  input  logic busy_i,
  input  logic wake_done,
  output logic wake_load,
  output logic sleeping,
  output logic stby_n_o,
  output logic start_o,
  output logic ready_o
);
  spc_state_e state_q, state_d;
  logic       pend_q;
  logic       want;
  logic       take;

  assign want = conv_req | pend_q;
  assign take = ((state_q == ST_IDLE) || (state_q == ST_SLEEP)) && want;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (want)      state_d = ST_LAUNCH;
      ST_LAUNCH:                state_d = ST_ARM;
      ST_ARM:    if (busy_i)    state_d = ST_RUN;
      ST_RUN:    if (!busy_i)   state_d = ST_SLEEP;
      ST_SLEEP:  if (want)      state_d = ST_WAKE;
      ST_WAKE:   if (wake_done) state_d = ST_LAUNCH;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take)          pend_q <= 1'b0;
      else if (conv_req) pend_q <= 1'b1;
    end
  end

  assign wake_load = (state_q == ST_SLEEP) && want;
  assign sleeping  = (state_q == ST_SLEEP);
  assign stby_n_o  = (state_q != ST_SLEEP);
  assign start_o   = (state_q == ST_LAUNCH);
  assign ready_o   = (state_q == ST_IDLE) || (state_q == ST_SLEEP);
endmodule

// File: rtl/stby_pwr_ctrl.sv
module stby_pwr_ctrl
  import spc_pkg::*;
#(
  parameter int unsigned WAKE_EXT   = 125,
  parameter int unsigned WAKE_SHORT = 625,
  parameter int unsigned WAKE_MID   = 125000,
  parameter int unsigned WAKE_LONG  = 1250000,
  parameter int unsigned SLEEP_MID  = 1250000,
  parameter int unsigned SLEEP_LONG = 125000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_req,
  input  logic busy_i,
  input  logic ref_ext_i,
  output logic stby_n_o,
  output logic start_o,
  output logic ready_o
);
  localparam int unsigned MAX_A  = (WAKE_EXT > WAKE_SHORT) ? WAKE_EXT : WAKE_SHORT;
  localparam int unsigned MAX_B  = (WAKE_MID > WAKE_LONG) ? WAKE_MID : WAKE_LONG;
  localparam int unsigned MAX_W  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned WW     = $clog2(MAX_W + 1);
  localparam int unsigned SW     = $clog2(SLEEP_LONG + 1);

  spc_tier_e tier;
  logic      sleeping;
  logic      wake_load;
  logic      wake_done;

  spc_sleep_meter #(
    .SLEEP_MID (SLEEP_MID),
    .SLEEP_LONG(SLEEP_LONG),
    .SW        (SW)
  ) u_meter (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleeping(sleeping),
    .ref_ext (ref_ext_i),
    .tier    (tier)
  );

  spc_wake_timer #(
    .WAKE_EXT  (WAKE_EXT),
    .WAKE_SHORT(WAKE_SHORT),
    .WAKE_MID  (WAKE_MID),
    .WAKE_LONG (WAKE_LONG),
    .WW        (WW)
  ) u_wake (
    .clk  (clk),
    .rst_n(rst_n),
    .load (wake_load),
    .tier (tier),
    .done (wake_done)
  );

  spc_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv_req (conv_req),
    .busy_i   (busy_i),
    .wake_done(wake_done),
    .wake_load(wake_load),
    .sleeping (sleeping),
    .stby_n_o (stby_n_o),
    .start_o  (start_o),
    .ready_o  (ready_o)
  );
endmodule

// File: rtl/spc_ctrl_checker.sv
module spc_ctrl_checker #(
  parameter int unsigned WAKE_EXT = 125
) (
  input logic clk,
  input logic rst_n,
  input logic conv_req,
  input logic busy_i,
  input logic ref_ext_i,
  input logic stby_n_o,
  input logic start_o,
  input logic ready_o
);
  logic        prev_stby_q;
  logic        prev_ext_q;
  logic        trk_q;
  logic        ext_l_q;
  logic [31:0] wcnt_q;
  logic        rise;

  assign rise = stby_n_o && !prev_stby_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_stby_q <= 1'b1;
      prev_ext_q  <= 1'b0;
      trk_q       <= 1'b0;
      ext_l_q     <= 1'b0;
      wcnt_q      <= '0;
    end else begin
      prev_stby_q <= stby_n_o;
      prev_ext_q  <= ref_ext_i;
      if (rise) begin
        trk_q   <= 1'b1;
        ext_l_q <= prev_ext_q;
        wcnt_q  <= 32'd1;
      end else if (start_o) begin
        trk_q <= 1'b0;
      end else if (trk_q) begin
        wcnt_q <= wcnt_q + 32'd1;
      end
    end
  end

  // R4: external-reference wake lasts exactly WAKE_EXT cycles
  always_ff @(posedge clk) begin
    if (rst_n && start_o && trk_q && ext_l_q)
      assert_ext_wake_R4: assert (wcnt_q == 32'(WAKE_EXT));
  end

  assert_idle_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && stby_n_o && conv_req) |=> start_o);

  assert_enter_sleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby_n_o && $past(stby_n_o)) |-> !$past(busy_i));

  assert_wake_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> !start_o);

  assert_start_awake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> stby_n_o);

  assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  assert_start_notready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !ready_o);

  assert_sleep_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_n_o |-> ready_o);
endmodule

bind stby_pwr_ctrl spc_ctrl_checker #(.WAKE_EXT(WAKE_EXT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .conv_req (conv_req),
  .busy_i   (busy_i),
  .ref_ext_i(ref_ext_i),
  .stby_n_o (stby_n_o),
  .start_o  (start_o),
  .ready_o  (ready_o)
);

// File: tb/stby_pwr_ctrl_tb.sv
module stby_pwr_ctrl_tb;
  localparam int WE = 2, T0 = 3, T1 = 5, T2 = 7, L0 = 4, L1 = 8, BLEN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_req = 1'b0;
  logic busy_i = 1'b0;
  logic ref_ext_i = 1'b0;
  logic stby_n_o, start_o, ready_o;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  stby_pwr_ctrl #(
    .WAKE_EXT(WE), .WAKE_SHORT(T0), .WAKE_MID(T1), .WAKE_LONG(T2),
    .SLEEP_MID(L0), .SLEEP_LONG(L1)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .busy_i(busy_i),
    .ref_ext_i(ref_ext_i), .stby_n_o(stby_n_o), .start_o(start_o),
    .ready_o(ready_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_wait(input int d, input bit ext);
    if (ext) return WE;
    if (d < L0) return T0;
    if (d < L1) return T1;
    return T2;
  endfunction

  function automatic string tier_tag(input int d, input bit ext);
    if (ext) return "R4 R11";
    if (d < L0) return "R5 R11";
    if (d < L1) return "R6 R11";
    return "R7 R11";
  endfunction

  // called at the negedge where start_o is seen; returns at first standby sample
  task automatic run_busy(input bit pulse_mid);
    busy_i = 1'b1;
    for (int i = 0; i < BLEN; i++) begin
      @(negedge clk);
      if (i == 0) begin
        check(start_o == 1'b0, "R8 single start", int'(start_o), 0);
        if (pulse_mid) conv_req = 1'b1;
      end
      if (i == 1) conv_req = 1'b0;
      check(stby_n_o == 1'b1 && ready_o == 1'b0, "R3 R9 awake busy",
            int'({stby_n_o, ready_o}), 2);
    end
    busy_i = 1'b0;
    @(negedge clk);
    check(stby_n_o == 1'b0 && ready_o == 1'b1, "R3 R9 standby after busy",
          int'({stby_n_o, ready_o}), 1);
  endtask

  // counts awake non-start samples from the current negedge until start_o
  task automatic measure_wait(output int w, output bit ok_ready);
    w = 0;
    ok_ready = 1'b1;
    while (!start_o && w < 100) begin
      if (ready_o || !stby_n_o) ok_ready = 1'b0;
      w++;
      @(negedge clk);
    end
  endtask

  initial begin
    int w;
    bit okr;
    int slp;
    @(negedge clk);
    check(stby_n_o == 1 && start_o == 0 && ready_o == 1, "R1 in reset",
          int'({stby_n_o, start_o, ready_o}), 5);
    rst_n = 1'b1;
    @(negedge clk);
    check(stby_n_o == 1 && start_o == 0 && ready_o == 1, "R1 after reset",
          int'({stby_n_o, start_o, ready_o}), 5);

    conv_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
    check(start_o == 1 && stby_n_o == 1 && ready_o == 0, "R2 idle start",
          int'({stby_n_o, start_o, ready_o}), 6);
    run_busy(1'b0);

    for (int e = 0; e < 2; e++) begin
      for (int n = 1; n <= L1 + 4; n++) begin
        for (int k = 1; k < n; k++) begin
          @(negedge clk);
          if (k == n - 1)
            check(stby_n_o == 0 && ready_o == 1 && start_o == 0, "R9 standby hold",
                  int'({stby_n_o, start_o, ready_o}), 1);
        end
        conv_req  = 1'b1;
        ref_ext_i = e[0];
        @(negedge clk);
        conv_req  = 1'b0;
        ref_ext_i = ~e[0];
        measure_wait(w, okr);
        check(w == exp_wait(n, e[0]), tier_tag(n, e[0]), w, exp_wait(n, e[0]));
        check(okr, "R9 ready low in wake", int'(okr), 1);
        check(start_o == 1'b1, "R8 start after wait", int'(start_o), 1);
        run_busy(1'b0);
      end
    end

    // held requests: several during wake and busy collapse to one
    ref_ext_i = 1'b0;
    conv_req  = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
    conv_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
    conv_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
    @(negedge clk);
    check(start_o == 1'b1, "R10 start after wake with held requests", int'(start_o), 1);
    run_busy(1'b1);
    slp = 1;
    @(negedge clk);
    while (!stby_n_o && slp < 50) begin
      slp++;
      @(negedge clk);
    end
    check(slp == 1, "R10 one standby cycle for held request", slp, 1);
    measure_wait(w, okr);
    check(w == T0, "R10 wait for D=1", w, T0);
    check(start_o == 1'b1, "R10 held start", int'(start_o), 1);
    run_busy(1'b0);
    begin
      int extra = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (start_o || stby_n_o) extra++;
      end
      check(extra == 0, "R10 no further start", extra, 0);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule